// File: doc/BRIEF.md
# Dead-Band Complementary Pair Generator

This block turns one raw PWM waveform into two gate-drive signals, A and B, for the two switches of a half bridge. Output A follows the input with a programmable delay on its rising edge only. Output B follows the input with a programmable delay on its falling edge only. Each delay is a count of clock periods, so neither output turns on until the other has had time to turn off. A polarity selector then inverts either output, both outputs or neither. This gives active-high, active-low and the two complementary drive styles.

The two delay counts are written to shadow inputs. Each count moves into its active register on a counter event that is chosen separately for that count: counter at zero, counter at period, either of these, or at once. The active values can therefore change at a safe point in the PWM period. A bypass setting sends the raw input to both outputs with no delays and no polarity change. All paths have the same latency: an input change sampled on clock edge k reaches the outputs on edge k+2, plus any programmed delay.

Top module: `dbpair_gen`

## Requirements
- R1: While `rst_n` is low, both outputs are 0 and both active delay counts are 0.
- R2: With `out_mode`=1 and polarity code 0, `out_a` rises RED+2 clock edges after the edge that first samples `pwm_in` high. It falls 2 edges after the edge that first samples `pwm_in` low. RED is the active rising count.
- R3: With `out_mode`=1 and polarity code 0, `out_b` rises 2 edges after `pwm_in` is first sampled high. It stays high until FED+2 edges after `pwm_in` is first sampled low. FED is the active falling count.
- R4: An active count of 0 adds no delay. The path then follows `pwm_in` two edges late.
- R5: If `pwm_in` is high for L cycles and L ≤ RED, no pulse appears on the rising-delayed path. If L > RED, that path gives one pulse of L−RED cycles.
- R6: Polarity code `pol_mode`: 0 gives A=rising path and B=falling path. 1 inverts both. 2 inverts only B. 3 inverts only A. The code is applied in the output register stage.
- R7: In the complementary codes 2 and 3, the two outputs are never both in their active level in the same cycle.
- R8: With `out_mode`=0, both outputs equal `pwm_in` two edges late, whatever the polarity code and the delay counts.
- R9: Load-mode encoding for each count: 00 loads the shadow at an edge where `evt_zero` is high. 01 loads where `evt_period` is high. 10 loads where either strobe is high. 11 loads the shadow at every edge. A loaded value governs the delay from the following edge onward.
- R10: The rising count and the falling count use their own load modes. A strobe that loads one count leaves the other count unchanged if that count's mode does not select the strobe.
- R11: Counts are `CNT_W` bits wide, 10 by default. The largest count, 1023, delays the edge by exactly 1023 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Time-base clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwm_in | input | 1 | Raw PWM waveform |
| evt_zero | input | 1 | Strobe: counter reached zero |
| evt_period | input | 1 | Strobe: counter reached period |
| out_mode | input | 1 | 1 = delayed pair, 0 = bypass |
| pol_mode | input | 2 | Polarity code (see R6) |
| red_load_mode | input | 2 | Load event for the rising count |
| fed_load_mode | input | 2 | Load event for the falling count |
| red_shadow | input | CNT_W | Shadow rising-edge count |
| fed_shadow | input | CNT_W | Shadow falling-edge count |
| out_a | output | 1 | Gate drive A |
| out_b | output | 1 | Gate drive B |

## Verification
The bench builds the block with the default `CNT_W` of 10. The full 1023-cycle delay fits inside the cycle budget, so it runs at the real field width rather than a narrowed copy. That reach lets a 1000-cycle pulse, shorter than the largest rising count, be swallowed completely. A 1100-cycle pulse then shows the exact 1023-cycle edge offset on both paths. Small counts of 0 to 9 cover the zero-delay pass-through, pulse widths on each side of the rising count, and the load-mode strobes landing between pulses.

// File: rtl/dbpair_pkg.sv
package dbpair_pkg;

   typedef enum logic [1:0] {
      LD_ZERO   = 2'b00,
      LD_PERIOD = 2'b01,
      LD_EITHER = 2'b10,
      LD_DIRECT = 2'b11
   } ld_mode_e;

   typedef enum logic [1:0] {
      POL_AH  = 2'd0,
      POL_AL  = 2'd1,
      POL_AHC = 2'd2,
      POL_ALC = 2'd3
   } pol_e;

endpackage

// File: rtl/dbpair_loader.sv
module dbpair_loader #(
   parameter int W = 10
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [1:0]   mode,
   input  logic         evt_zero,
   input  logic         evt_period,
   input  logic [W-1:0] shadow,
   output logic [W-1:0] active
);
   import dbpair_pkg::*;

   logic load_now;

   // R9: pick the transfer event for this count
   always_comb begin
      case (ld_mode_e'(mode))
         LD_ZERO:   load_now = evt_zero;
         LD_PERIOD: load_now = evt_period;
         LD_EITHER: load_now = evt_zero | evt_period;
         default:   load_now = 1'b1;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)        active <= '0;
      else if (load_now) active <= shadow;
   end

endmodule

// File: rtl/dbpair_edge_delay.sv
module dbpair_edge_delay #(
   parameter int W       = 10,
   parameter bit RISING  = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         sig_in,
   input  logic [W-1:0] dly,
   output logic         sig_out
);

   logic [W-1:0] cnt;

   generate
      if (RISING) begin : g_rise
         // R2/R5: turn on only after sig_in has stayed high past the count
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               cnt     <= '0;
               sig_out <= 1'b0;
            end else if (!sig_in) begin
               cnt     <= '0;
               sig_out <= 1'b0;
            end else if (cnt >= dly) begin
               sig_out <= 1'b1;
            end else begin
               cnt     <= cnt + 1'b1;
               sig_out <= 1'b0;
            end
         end
      end else begin : g_fall
         // R3: hold high for the count after sig_in drops
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               cnt     <= '0;
               sig_out <= 1'b0;
            end else if (sig_in) begin
               cnt     <= '0;
               sig_out <= 1'b1;
            end else if (cnt >= dly) begin
               sig_out <= 1'b0;
            end else begin
               cnt     <= cnt + 1'b1;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/dbpair_outstage.sv
module dbpair_outstage (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       full_en,
   input  logic [1:0] pol,
   input  logic       red_s,
   input  logic       fed_s,
   input  logic       byp_s,
   output logic       out_a,
   output logic       out_b
);
   import dbpair_pkg::*;

   logic nxt_a, nxt_b;

   // R6/R8: routing and polarity
   always_comb begin
      if (!full_en) begin
         nxt_a = byp_s;
         nxt_b = byp_s;
      end else begin
         case (pol_e'(pol))
            POL_AH:  begin nxt_a =  red_s; nxt_b =  fed_s; end
            POL_AL:  begin nxt_a = ~red_s; nxt_b = ~fed_s; end
            POL_AHC: begin nxt_a =  red_s; nxt_b = ~fed_s; end
            default: begin nxt_a = ~red_s; nxt_b =  fed_s; end
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_a <= 1'b0;
         out_b <= 1'b0;
      end else begin
         out_a <= nxt_a;
         out_b <= nxt_b;
      end
   end

endmodule

// File: rtl/dbpair_gen.sv
module dbpair_gen #(
   parameter int CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pwm_in,
   input  logic             evt_zero,
   input  logic             evt_period,
   input  logic             out_mode,
   input  logic [1:0]       pol_mode,
   input  logic [1:0]       red_load_mode,
   input  logic [1:0]       fed_load_mode,
   input  logic [CNT_W-1:0] red_shadow,
   input  logic [CNT_W-1:0] fed_shadow,
   output logic             out_a,
   output logic             out_b
);

   generate
      if (CNT_W < 1 || CNT_W > 16) begin : g_bad_width
         $error("dbpair_gen: CNT_W must lie in 1..16");
      end
   endgenerate

   logic             pwm_q, byp_q;
   logic             red_s, fed_s;
   logic [CNT_W-1:0] red_act, fed_act;

   // input sample stage, plus a matching stage for the bypass path
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pwm_q <= 1'b0;
         byp_q <= 1'b0;
      end else begin
         pwm_q <= pwm_in;
         byp_q <= pwm_q;
      end
   end

   dbpair_loader #(.W(CNT_W)) u_red_ld (
      .clk(clk), .rst_n(rst_n), .mode(red_load_mode),
      .evt_zero(evt_zero), .evt_period(evt_period),
      .shadow(red_shadow), .active(red_act)
   );

   dbpair_loader #(.W(CNT_W)) u_fed_ld (
      .clk(clk), .rst_n(rst_n), .mode(fed_load_mode),
      .evt_zero(evt_zero), .evt_period(evt_period),
      .shadow(fed_shadow), .active(fed_act)
   );

   dbpair_edge_delay #(.W(CNT_W), .RISING(1'b1)) u_red_dly (
      .clk(clk), .rst_n(rst_n), .sig_in(pwm_q), .dly(red_act), .sig_out(red_s)
   );

   dbpair_edge_delay #(.W(CNT_W), .RISING(1'b0)) u_fed_dly (
      .clk(clk), .rst_n(rst_n), .sig_in(pwm_q), .dly(fed_act), .sig_out(fed_s)
   );

   dbpair_outstage u_out (
      .clk(clk), .rst_n(rst_n), .full_en(out_mode), .pol(pol_mode),
      .red_s(red_s), .fed_s(fed_s), .byp_s(byp_q),
      .out_a(out_a), .out_b(out_b)
   );

endmodule

// File: rtl/dbpair_chk.sv
module dbpair_chk #(
   parameter int CNT_W = 10
) (
   input logic             clk,
   input logic             rst_n,
   input logic             pwm_q,
   input logic             red_s,
   input logic             fed_s,
   input logic             evt_zero,
   input logic             out_mode,
   input logic [1:0]       pol_mode,
   input logic [1:0]       red_load_mode,
   input logic [1:0]       fed_load_mode,
   input logic [CNT_W-1:0] red_shadow,
   input logic [CNT_W-1:0] red_act,
   input logic [CNT_W-1:0] fed_act,
   input logic             out_a,
   input logic             out_b
);

   assert_red_rise_input_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(red_s) |-> $past(pwm_q));

   assert_fed_fall_input_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(fed_s) |-> !$past(pwm_q));

   assert_red_within_fed_R5: assert property (@(posedge clk) disable iff (!rst_n)
      red_s |-> fed_s);

   assert_no_overlap_ahc_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_mode && pol_mode == 2'd2) |=> !(out_a && out_b));

   assert_no_overlap_alc_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_mode && pol_mode == 2'd3) |=> (out_a || out_b));

   assert_bypass_equal_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !out_mode |=> (out_a == out_b));

   assert_direct_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (red_load_mode == 2'b11) |=> (red_act == $past(red_shadow)));

   assert_hold_unselected_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (fed_load_mode == 2'b00 && !evt_zero) |=> $stable(fed_act));

endmodule

bind dbpair_gen dbpair_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .pwm_q(pwm_q), .red_s(red_s), .fed_s(fed_s),
   .evt_zero(evt_zero), .out_mode(out_mode), .pol_mode(pol_mode),
   .red_load_mode(red_load_mode), .fed_load_mode(fed_load_mode),
   .red_shadow(red_shadow), .red_act(red_act), .fed_act(fed_act),
   .out_a(out_a), .out_b(out_b)
);

// File: tb/sim_dbpair_gen.sv
module sim_dbpair_gen;
   localparam int CLK_PERIOD = 10;
   localparam int W = 10;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         pwm_r = 1'b0, ez_r = 1'b0, ep_r = 1'b0, full_r = 1'b1;
   logic [1:0]   pol_r = 2'd0, rmode_r = 2'b11, fmode_r = 2'b11;
   logic [W-1:0] rsh_r = '0, fsh_r = '0;
   logic         out_a, out_b;

   always #(CLK_PERIOD/2) clk = ~clk;

   dbpair_gen #(.CNT_W(W)) u0 (
      .clk(clk), .rst_n(rst_n), .pwm_in(pwm_r), .evt_zero(ez_r), .evt_period(ep_r),
      .out_mode(full_r), .pol_mode(pol_r), .red_load_mode(rmode_r),
      .fed_load_mode(fmode_r), .red_shadow(rsh_r), .fed_shadow(fsh_r),
      .out_a(out_a), .out_b(out_b)
   );

   typedef struct {
      int    idx;
      bit    red;
      bit    fed;
      bit    inb;
      string tag;
   } item_t;

   item_t sb[$];
   item_t it, pushed;
   int    cyc = 0, checks = 0, fails = 0;
   int    red_m = 0, fed_m = 0, hi_run = 0, lo_run = 1000000;
   string tag = "R1";
   bit    done = 1'b0;

   function automatic bit sel(input logic [1:0] m, input bit z, input bit p);
      case (m)
         2'b00: sel = z;
         2'b01: sel = p;
         2'b10: sel = z | p;
         default: sel = 1'b1;
      endcase
   endfunction

   // driver: one call per clock, entered at a falling edge
   task automatic step(input bit pwm, input bit z = 1'b0, input bit p = 1'b0);
      pwm_r = pwm; ez_r = z; ep_r = p;
      if (sel(rmode_r, z, p)) red_m = int'(rsh_r);
      if (sel(fmode_r, z, p)) fed_m = int'(fsh_r);
      if (pwm) begin hi_run++; lo_run = 0; end
      else begin lo_run = (lo_run < 1000000) ? lo_run + 1 : lo_run; hi_run = 0; end
      pushed.idx = cyc + 1;
      pushed.red = pwm && (hi_run >= red_m + 1);
      pushed.fed = pwm || (lo_run <= fed_m);
      pushed.inb = pwm;
      pushed.tag = tag;
      sb.push_back(pushed);
      @(negedge clk);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(1'b0);
   endtask

   task automatic pulse(input int w);
      for (int i = 0; i < w; i++) step(1'b1);
   endtask

   // monitor: compares after each edge
   always @(posedge clk) begin
      bit ea, eb;
      #1;
      if (rst_n) begin
         cyc++;
         if (sb.size() > 0 && sb[0].idx == cyc - 2) begin
            it = sb.pop_front();
            if (!full_r) begin ea = it.inb; eb = it.inb; end
            else case (pol_r)
               2'd0: begin ea =  it.red; eb =  it.fed; end
               2'd1: begin ea = !it.red; eb = !it.fed; end
               2'd2: begin ea =  it.red; eb = !it.fed; end
               default: begin ea = !it.red; eb = it.fed; end
            endcase
            checks++;
            if (out_a !== ea || out_b !== eb) begin
               fails++;
               $display("FAIL %s cyc %0d: a/b = %b%b expected %b%b", it.tag, cyc, out_a, out_b, ea, eb);
            end
            if (full_r && pol_r == 2'd2 && out_a && out_b) begin
               fails++;
               $display("FAIL R7 cyc %0d: overlap a/b = %b%b expected not 11", cyc, out_a, out_b);
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: run incomplete, actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      checks++;   // R1 reset state
      if (out_a !== 1'b0 || out_b !== 1'b0) begin
         fails++;
         $display("FAIL R1: a/b = %b%b expected 00", out_a, out_b);
      end
      rst_n = 1'b1;
      tag = "R1"; idle(6);

      // R2 R3: basic delays, immediate loading
      tag = "R2 R3";
      rsh_r = 10'd5; fsh_r = 10'd3; idle(10);
      pulse(20); idle(20); pulse(9); idle(15);

      // R4: zero counts
      tag = "R4";
      rsh_r = 10'd0; fsh_r = 10'd0; idle(4);
      pulse(1); idle(1); pulse(3); idle(2); pulse(7); idle(6);

      // R5: pulses around the rising count
      tag = "R5";
      rsh_r = 10'd6; fsh_r = 10'd2; idle(8);
      pulse(3); idle(10); pulse(6); idle(10); pulse(7); idle(10); pulse(10); idle(10);

      // R6 R7: polarity codes
      rsh_r = 10'd3; fsh_r = 10'd4; idle(8);
      for (int p = 0; p < 4; p++) begin
         pol_r = 2'(p);
         tag = (p >= 2) ? "R7" : "R6";
         idle(3); pulse(12); idle(9); pulse(2); idle(9);
      end

      // R8: bypass ignores polarity and counts
      tag = "R8";
      full_r = 1'b0;
      for (int p = 0; p < 4; p++) begin
         pol_r = 2'(p);
         pulse(5); idle(3); pulse(1); idle(2);
      end
      full_r = 1'b1; pol_r = 2'd0; idle(12);

      // R9: event-selected loading
      tag = "R9";
      rsh_r = 10'd2; fsh_r = 10'd2; idle(3);
      rmode_r = 2'b00; fmode_r = 2'b00;
      rsh_r = 10'd7; fsh_r = 10'd4;
      pulse(12); idle(12);                   // old counts 2/2 still active
      step(1'b0, 1'b1, 1'b0); idle(2);       // zero strobe loads 7/4
      pulse(12); idle(12);
      rmode_r = 2'b01; fmode_r = 2'b01;
      rsh_r = 10'd3; fsh_r = 10'd1;
      step(1'b0, 1'b1, 1'b0); idle(2);       // zero strobe ignored
      pulse(12); idle(12);
      step(1'b0, 1'b0, 1'b1); idle(2);       // period strobe loads 3/1
      pulse(12); idle(12);
      rmode_r = 2'b10; fmode_r = 2'b10;
      rsh_r = 10'd5; fsh_r = 10'd5;
      step(1'b0, 1'b0, 1'b1); idle(2);
      pulse(12); idle(12);
      rsh_r = 10'd1; fsh_r = 10'd2;
      step(1'b0, 1'b1, 1'b0); idle(2);
      pulse(12); idle(12);

      // R10: independent load modes
      tag = "R10";
      rmode_r = 2'b00; fmode_r = 2'b01;
      rsh_r = 10'd9; fsh_r = 10'd6;
      step(1'b0, 1'b1, 1'b0); idle(2);       // red loads 9, fed keeps 2
      pulse(14); idle(14);
      step(1'b0, 1'b0, 1'b1); idle(2);       // fed loads 6
      pulse(14); idle(14);

      // R11: largest count
      tag = "R11";
      rmode_r = 2'b11; fmode_r = 2'b11;
      idle(1100);
      rsh_r = 10'd1023; fsh_r = 10'd1023;
      idle(4);
      pulse(1000); idle(1100);
      pulse(1100); idle(1100);

      idle(5);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule